// File: doc/BRIEF.md
# Strobed Byte-Port Configuration and Routing Slave

This block is the device end of a narrow configuration port. A host drives one 8-bit byte at a time. The top bit acts as a strobe, and the lower seven bits carry a payload. The slave synchronises the byte into its own clock. On each rising edge of the strobe it takes the payload and classifies it:

- A payload with bit 6 set selects one of 64 six-bit registers.
- A payload with bit 6 clear is a value. It is written into the register selected most recently.

The selected register's contents are always presented on a read-back field of the output word. A host therefore reads a register by strobing its address and then sampling the word.

Four of the registers stage a routing request. Registers 0 and 1 hold the upper and lower halves of a 12-bit destination index. Registers 2 and 3 hold the halves of a 12-bit source index. Writing register 3 commits the request into a destination-indexed table, so every destination has exactly one source. Any number of destinations may name the same source. A query port reads the table back.

Top module: `cfgp_route_slave`

## Requirements
- R1: A payload is acted on only at a rising edge of `port_byte[7]`. Payload changes while the strobe is held high, and falling edges, have no effect. The action is visible at the outputs no later than 4 clock cycles after the rising edge at the pin.
- R2: A payload from 0x40 to 0x7F selects register number (payload − 0x40).
- R3: A payload from 0x00 to 0x3F is written into the selected register. The selection persists, so consecutive values go to the same register.
- R4: A value byte that arrives before any register has been selected since reset changes no register and no table entry.
- R5: `rd_word[13:8]` shows the selected register's contents. All other bits of `rd_word` read zero, and the whole word reads zero while no register is selected.
- R6: A write to register 3 loads the table entry for destination {reg0, reg1} with source {reg2, value being written}. The value written in that same cycle is used, not the old contents of register 3.
- R7: Writes to registers 0, 1 and 2, and to registers 4 to 63, never change the table. A later commit to a destination replaces its earlier source, and several destinations may hold the same source.
- R8: A commit whose destination is NUM_DST or above leaves the table unchanged. A query for such a destination returns 0.
- R9: After reset, every register and every table entry is 0, and `rd_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_byte | input | 8 | Host byte: bit 7 is the strobe, bits 6:0 the payload (asynchronous to clk) |
| rd_word | output | 16 | Read word; bits 13:8 carry the selected register, all other bits zero |
| route_dst | input | 12 | Destination index to look up in the routing table |
| route_src | output | 12 | Source stored for `route_dst` (0 if out of range) |

## Verification
In a single clock cycle, a value byte addressed to register 3 both writes that register and commits a routing entry whose low source half is that same value. The bench provokes this repeatedly, in directed and random routing sequences, with a new low-source value each time. It judges the result by reading the table back and comparing it with a model that joins the stored halves to the incoming value. A second overlap occurs when a write changes the register being read back. That case is judged through `rd_word` after every value byte.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int PAY_W  = 7;
  localparam int VAL_W  = 6;
  localparam int NREG   = 1 << VAL_W;
  localparam int RIDX_W = 2 * VAL_W;

  typedef logic [PAY_W-1:0]  payload_t;
  typedef logic [VAL_W-1:0]  val_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  // Staging registers whose position the routing logic decodes
  localparam val_t REG_DST_HI = val_t'(0);
  localparam val_t REG_DST_LO = val_t'(1);
  localparam val_t REG_SRC_HI = val_t'(2);
  localparam val_t REG_SRC_LO = val_t'(3);

  function automatic logic is_addr_byte(payload_t p);
    return p[PAY_W-1];
  endfunction

  function automatic val_t payload_field(payload_t p);
    return p[VAL_W-1:0];
  endfunction

  function automatic ridx_t join_halves(val_t hi, val_t lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/cfgp_strobe_sync.sv
module cfgp_strobe_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic         rise_pulse
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic                     strobe_prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_prev <= 1'b0;
    else        strobe_prev <= sync_out[W-1];
  end

  assign rise_pulse = sync_out[W-1] & ~strobe_prev;

  // R1: one action per strobe edge
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/cfgp_decoder.sv
module cfgp_decoder
  import cfgp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  payload_t payload,
  output val_t     cur_idx,
  output logic     idx_valid,
  output logic     wr_en,
  output val_t     wr_val
);
  logic addr_take;
  logic val_take;

  assign addr_take = take &  is_addr_byte(payload);
  assign val_take  = take & ~is_addr_byte(payload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx   <= '0;
      idx_valid <= 1'b0;
    end else if (addr_take) begin
      cur_idx   <= payload_field(payload);
      idx_valid <= 1'b1;
    end
  end

  assign wr_en  = val_take & idx_valid;
  assign wr_val = payload_field(payload);

  // R2: an address byte selects the register named by its low six bits
  a_r2_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    addr_take |=> (idx_valid && cur_idx == $past(payload[VAL_W-1:0])));

  // R4: once a register is selected, the selection never lapses before reset
  a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |=> idx_valid);
endmodule

// File: rtl/cfgp_reg_bank.sv
module cfgp_reg_bank
  import cfgp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  val_t wr_idx,
  input  val_t wr_val,
  input  val_t rd_idx,
  output val_t rd_val,
  output val_t dst_hi,
  output val_t dst_lo,
  output val_t src_hi
);
  logic [NREG-1:0][VAL_W-1:0] regs;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            regs[g] <= '0;
        else if (wr_en && wr_idx == val_t'(g)) regs[g] <= wr_val;
      end
    end
  endgenerate

  assign rd_val = regs[rd_idx];
  assign dst_hi = regs[REG_DST_HI];
  assign dst_lo = regs[REG_DST_LO];
  assign src_hi = regs[REG_SRC_HI];

  // R3: a value write lands in the selected register
  a_r3_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/cfgp_route_table.sv
module cfgp_route_table #(
  parameter int NUM_DST = 16,
  parameter int IDX_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] dst,
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] query_dst,
  output logic [IDX_W-1:0] query_src
);
  localparam int TIDX_W = (NUM_DST > 1) ? $clog2(NUM_DST) : 1;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_DST);

  logic [NUM_DST-1:0][IDX_W-1:0] tbl;
  logic                          in_range;
  logic                          q_in_range;

  assign in_range   = {1'b0, dst} < LIMIT;
  assign q_in_range = {1'b0, query_dst} < LIMIT;

  generate
    for (genvar g = 0; g < NUM_DST; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          tbl[g] <= '0;
        else if (commit && in_range && dst == IDX_W'(g))
          tbl[g] <= src;
      end
    end
  endgenerate

  assign query_src = q_in_range ? tbl[query_dst[TIDX_W-1:0]] : '0;

  // R6: a commit to a valid destination stores the source there
  a_r6_commit_store: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && in_range) |=> tbl[$past(dst[TIDX_W-1:0])] == $past(src));

  // R8: an out-of-range commit leaves the table untouched
  a_r8_range_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !in_range) |=> $stable(tbl));

  // R7: the table only moves on a commit
  a_r7_no_stray_update: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(tbl));
endmodule

// File: rtl/cfgp_route_slave.sv
module cfgp_route_slave
  import cfgp_pkg::*;
#(
  parameter int NUM_DST     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        port_byte,
  output logic [15:0]       rd_word,
  input  logic [RIDX_W-1:0] route_dst,
  output logic [RIDX_W-1:0] route_src
);
  localparam int BYTE_W   = PAY_W + 1;
  localparam int RD_LSB   = 8;
  localparam int RD_FIELD = 7;

  logic [BYTE_W-1:0] byte_sync;
  logic              take;
  payload_t          payload;
  val_t              cur_idx;
  logic              idx_valid;
  logic              wr_en;
  val_t              wr_val;
  val_t              bank_rd;
  val_t              dst_hi, dst_lo, src_hi;
  logic              commit;
  ridx_t             commit_dst;
  ridx_t             commit_src;
  logic [RD_FIELD-1:0] rd_field;

  cfgp_strobe_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(port_byte),
    .sync_out(byte_sync), .rise_pulse(take)
  );

  assign payload = byte_sync[PAY_W-1:0];

  cfgp_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .take(take), .payload(payload),
    .cur_idx(cur_idx), .idx_valid(idx_valid), .wr_en(wr_en), .wr_val(wr_val)
  );

  cfgp_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(cur_idx),
    .wr_val(wr_val), .rd_idx(cur_idx), .rd_val(bank_rd),
    .dst_hi(dst_hi), .dst_lo(dst_lo), .src_hi(src_hi)
  );

  // The low source half comes from the value being written this cycle
  assign commit     = wr_en && (cur_idx == REG_SRC_LO);
  assign commit_dst = join_halves(dst_hi, dst_lo);
  assign commit_src = join_halves(src_hi, wr_val);

  cfgp_route_table #(.NUM_DST(NUM_DST), .IDX_W(RIDX_W)) u_route (
    .clk(clk), .rst_n(rst_n), .commit(commit), .dst(commit_dst),
    .src(commit_src), .query_dst(route_dst), .query_src(route_src)
  );

  assign rd_field = idx_valid ? {1'b0, bank_rd} : '0;
  assign rd_word  = {1'b0, rd_field, {RD_LSB{1'b0}}};

  // R4: no value write while nothing is selected
  a_r4_no_blind_write: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_valid |=> $stable(rd_word));

  // R5: padding bits of the read word stay low
  a_r5_read_pad: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[15:14] == 2'b00 && rd_word[7:0] == 8'h00);
endmodule

// File: tb/cfgp_route_slave_test.sv
module cfgp_route_slave_test;
  localparam int NUM_DST = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  port_byte = 8'h00;
  logic [15:0] rd_word;
  logic [11:0] route_dst = '0;
  logic [11:0] route_src;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  int m_reg [64];
  int m_tbl [NUM_DST];
  int m_cur = 0;
  bit m_sel = 0;

  always #10 clk = ~clk;

  cfgp_route_slave #(.NUM_DST(NUM_DST)) uut (
    .clk(clk), .rst_n(rst_n), .port_byte(port_byte), .rd_word(rd_word),
    .route_dst(route_dst), .route_src(route_src)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd();
    return m_sel ? (m_reg[m_cur] * 256) : 0;
  endfunction

  function automatic int exp_route(int d);
    return (d < NUM_DST) ? m_tbl[d] : 0;
  endfunction

  task automatic model(input int p);
    if (p >= 64) begin
      m_cur = p - 64;
      m_sel = 1;
    end else if (m_sel) begin
      m_reg[m_cur] = p;
      if (m_cur == 3) begin
        int d;
        d = m_reg[0] * 64 + m_reg[1];
        if (d < NUM_DST) m_tbl[d] = m_reg[2] * 64 + p;
      end
    end
  endtask

  task automatic send(input int p);
    @(negedge clk) port_byte = {1'b0, 7'(p)};
    repeat (3) @(negedge clk);
    port_byte = {1'b1, 7'(p)};
    repeat (5) @(negedge clk);
    model(p);
  endtask

  task automatic route(input int d, input int s);
    send(64 + 0); send((d / 64) % 64);
    send(64 + 1); send(d % 64);
    send(64 + 2); send((s / 64) % 64);
    send(64 + 3); send(s % 64);
  endtask

  task automatic check_rd(input string tag);
    chk(rd_word == 16'(exp_rd()), tag, int'(rd_word), exp_rd());
  endtask

  task automatic check_route(input int d, input string tag);
    @(negedge clk) route_dst = 12'(d);
    @(negedge clk);
    chk(route_src == 12'(exp_route(d)), tag, int'(route_src), exp_route(d));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_reg[i] = 0;
    for (int i = 0; i < NUM_DST; i++) m_tbl[i] = 0;
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: reset state
    check_rd("R9");
    check_route(0, "R9");
    check_route(NUM_DST - 1, "R9");

    // R4: value before any selection is ignored
    send(6'h2a);
    check_rd("R4");
    check_route(0, "R4");

    // R2 / R3 / R5: select, write, read back, persistent selection
    send(64 + 5); check_rd("R2");
    send(6'h11);  check_rd("R3");
    send(6'h3f);  check_rd("R3");
    chk(rd_word[13:8] == 6'h3f, "R5", int'(rd_word[13:8]), 'h3f);
    send(64 + 63); check_rd("R5");
    send(64 + 5);  check_rd("R5");

    // R1: payload change with strobe held high, then falling edge: no action
    @(negedge clk) port_byte = 8'h80 | 8'h07;
    repeat (6) @(negedge clk);
    check_rd("R1");
    @(negedge clk) port_byte = 8'h01;
    repeat (6) @(negedge clk);
    check_rd("R1");

    // R6: commit uses value written in the same cycle
    route(3, 12'hABC);
    check_route(3, "R6");
    send(64 + 3); send(6'h15);
    check_route(3, "R6");

    // R7: shared source, replacement, writes to other registers
    route(7, 12'h123);
    route(9, 12'h123);
    check_route(7, "R7");
    check_route(9, "R7");
    route(7, 12'h456);
    check_route(7, "R7");
    send(64 + 2); send(6'h3e);
    send(64 + 0); send(6'h00);
    send(64 + 1); send(6'h09);
    send(64 + 40); send(6'h21);
    check_route(9, "R7");
    check_rd("R7");

    // R8: out-of-range destinations
    route(NUM_DST, 12'hFFF);
    route(12'h0C0 + 2, 12'h777);
    for (int d = 0; d < NUM_DST; d++) check_route(d, "R8");
    check_route(NUM_DST, "R8");
    check_route(12'hFFF, "R8");

    // Random mix
    for (int n = 0; n < 150; n++) begin
      int op;
      op = int'($urandom_range(0, 3));
      if (op == 0) begin
        int d, s;
        d = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 4095))
                                        : int'($urandom_range(0, NUM_DST + 2));
        s = int'($urandom_range(0, 4095));
        route(d, s);
        check_route(d, "R6");
      end else begin
        send(64 + int'($urandom_range(0, 63)));
        check_rd("R2");
        send(int'($urandom_range(0, 63)));
        check_rd("R3");
        check_route(int'($urandom_range(0, NUM_DST - 1)), "R7");
      end
    end
    for (int d = 0; d < NUM_DST; d++) check_route(d, "R6");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule